// File: doc/BRIEF.md
# Keyed-Access Watchdog Timer

This block guards a system against hung software. A 32-bit up-counter advances by one on each cycle in which the timebase input `tick` is high, provided the watchdog is enabled. Software keeps the counter away from its limit by writing a two-word feed key to the control address. The control register cannot be changed by a plain write. It accepts a new value only as the third word of a three-word unlock sequence.

When the counter reaches the period selected by a one-hot code, the block does one of two things. In reset mode it emits a one-cycle system reset pulse. In interrupt mode it sets a sticky status flag, which drives the interrupt output, and restarts counting. If a second period ends without a feed in between, a reset pulse follows. Software can read the counter as two 16-bit halves. Reading the low half captures the high half, so that the two reads form one consistent 32-bit value. Periods are given as tick counts through parameters.

Top module: `keyed_watchdog`

## Requirements
- R1: After reset the control register reads 0000h, the counter reads zero, and both `wdt_irq` and `wdt_sys_rst` are low.
- R2: Writes of 3333h, then CCCCh, then a value V to address 0 load V into the control register. Bit 15 of the register is enable, bit 14 is the action (1 = reset, 0 = interrupt), and bits 7:0 are the period code. Bits 13 and 11:8 always read zero.
- R3: A write to address 0 that does not complete the unlock sequence leaves the control register unchanged.
- R4: Writes of AAAAh then 5555h to address 0 clear the counter. They leave the control register unchanged.
- R5: A write to address 0 that breaks a partly received sequence returns the tracking to idle. That same word is then evaluated again as a possible first key word. Writes to other addresses do not affect the tracking.
- R6: While enable is 0, the counter holds at zero. While enable is 1, the counter increments once per cycle in which `tick` is high.
- R7: When the counter reaches the limit, a timeout occurs. The limit is SHORT_TICKS for code 01h and BASE_TICKS shifted left by (i-1) for code bit i, where i is 1 to 7. In reset mode a timeout drives `wdt_sys_rst` high for exactly one cycle and restarts the counter from zero.
- R8: A period code that is zero or has more than one bit set never causes a timeout.
- R9: In interrupt mode, the first timeout sets control bit 12 and `wdt_irq`, and restarts the counter from zero.
- R10: In interrupt mode, a timeout that follows an interrupt timeout with no feed in between produces a reset pulse. With a feed in between, the second timeout only raises the interrupt again.
- R11: Control bit 12 is cleared only by an unlocked load with bit 12 written as 0. Writing 1 to it never sets it.
- R12: A read of address 1 returns the counter's low 16 bits and captures the high 16 bits. A read of address 2 returns the captured high half, whatever the counter has done since.
- R13: If a feed completes in the same cycle as the tick that would reach the limit, the feed wins. The counter clears and no timeout occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse; each high cycle counts once |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (captures high half on address 1) |
| bus_addr | input | 2 | 0 = control, 1 = counter low, 2 = captured counter high |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register |
| wdt_irq | output | 1 | Interrupt request; mirrors control bit 12 |
| wdt_sys_rst | output | 1 | One-cycle system reset pulse |

## Verification
Two events can land on the same clock edge: a feed completing, and the tick that brings the counter to its limit. The directed case provokes this by sending the 5555h feed word with `tick` held high in the cycle where the counter sits one below the limit. It then checks that no reset pulse appears and that the counter reads zero. The random phase produces the same clash, and also overlaps loads with timeouts. Every cycle is compared against a bench model written from the requirements.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int DATA_W = 16;
    localparam int CNT_W  = 32;
    localparam int CODE_W = 8;

    localparam logic [DATA_W-1:0] KEY_LOAD_A = 16'h3333;
    localparam logic [DATA_W-1:0] KEY_LOAD_B = 16'hCCCC;
    localparam logic [DATA_W-1:0] KEY_FEED_A = 16'hAAAA;
    localparam logic [DATA_W-1:0] KEY_FEED_B = 16'h5555;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_CNT_LO = 2'd1;
    localparam logic [1:0] ADDR_CNT_HI = 2'd2;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_LOAD1,
        SEQ_LOAD2,
        SEQ_FEED1
    } seq_e;

    typedef struct packed {
        logic              en;
        logic              rst_mode;
        logic              zero13;
        logic              flag;
        logic [3:0]        zero_mid;
        logic [CODE_W-1:0] code;
    } ctrl_t;

endpackage

// File: rtl/wdt_keyseq.sv
module wdt_keyseq
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic              load_pulse,
    output logic              feed_pulse
);

    seq_e seq_d, seq_q;

    // A word is judged as a fresh first key whenever the pending sequence breaks
    function automatic seq_e first_key(input logic [DATA_W-1:0] w);
        if (w == KEY_LOAD_A)      return SEQ_LOAD1;
        else if (w == KEY_FEED_A) return SEQ_FEED1;
        else                      return SEQ_IDLE;
    endfunction

    always_comb begin
        seq_d      = seq_q;
        load_pulse = 1'b0;
        feed_pulse = 1'b0;
        if (wr_ctrl) begin
            unique case (seq_q)
                SEQ_LOAD2: begin
                    load_pulse = 1'b1;
                    seq_d      = SEQ_IDLE;
                end
                SEQ_LOAD1: begin
                    if (wdata == KEY_LOAD_B) seq_d = SEQ_LOAD2;
                    else                     seq_d = first_key(wdata);
                end
                SEQ_FEED1: begin
                    if (wdata == KEY_FEED_B) begin
                        feed_pulse = 1'b1;
                        seq_d      = SEQ_IDLE;
                    end else begin
                        seq_d = first_key(wdata);
                    end
                end
                default: seq_d = first_key(wdata);
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_IDLE;
        else        seq_q <= seq_d;
    end

    // R5: one written word completes at most one sequence
    a_r5_one_action: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_pulse && feed_pulse));

endmodule

// File: rtl/wdt_period_sel.sv
module wdt_period_sel
    import wdt_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 1,
    parameter int unsigned BASE_TICKS  = 1000
) (
    input  logic [CODE_W-1:0] code,
    output logic [CNT_W-1:0]  limit,
    output logic              limit_ok
);

    logic [CNT_W-1:0] cand [CODE_W];

    generate
        for (genvar i = 0; i < CODE_W; i++) begin : g_cand
            if (i == 0) begin : g_short
                assign cand[i] = code[i] ? CNT_W'(SHORT_TICKS) : '0;
            end else begin : g_long
                assign cand[i] = code[i] ? (CNT_W'(BASE_TICKS) << (i - 1)) : '0;
            end
        end
    endgenerate

    always_comb begin
        limit = '0;
        for (int i = 0; i < CODE_W; i++) limit = limit | cand[i];
        limit_ok = $onehot(code);
    end

endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned SHORT_TICKS = 1,
    parameter int unsigned BASE_TICKS  = 1000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [15:0] bus_rdata,
    output logic        wdt_irq,
    output logic        wdt_sys_rst
);

    localparam int HALF_W = CNT_W / 2;

    typedef struct packed {
        ctrl_t              ctrl;
        logic [CNT_W-1:0]   cnt;
        logic               pend;
        logic [HALF_W-1:0]  hi_cap;
        logic               rst_pulse;
    } state_t;

    state_t st_d, st_q;

    logic             wr_ctrl, load, feed, tmo, lim_ok;
    logic [CNT_W-1:0] lim;

    assign wr_ctrl = bus_wr && (bus_addr == ADDR_CTRL);

    wdt_keyseq u_keyseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_ctrl   (wr_ctrl),
        .wdata     (bus_wdata),
        .load_pulse(load),
        .feed_pulse(feed)
    );

    wdt_period_sel #(
        .SHORT_TICKS(SHORT_TICKS),
        .BASE_TICKS (BASE_TICKS)
    ) u_period (
        .code    (st_q.ctrl.code),
        .limit   (lim),
        .limit_ok(lim_ok)
    );

    always_comb begin
        st_d           = st_q;
        st_d.rst_pulse = 1'b0;

        // Feed has priority over a timeout on the same edge
        tmo = st_q.ctrl.en && tick && !feed && lim_ok
              && ((st_q.cnt + CNT_W'(1)) == lim);

        if (load) begin
            st_d.ctrl.en       = bus_wdata[15];
            st_d.ctrl.rst_mode = bus_wdata[14];
            st_d.ctrl.zero13   = 1'b0;
            st_d.ctrl.flag     = st_q.ctrl.flag & bus_wdata[12];
            st_d.ctrl.zero_mid = '0;
            st_d.ctrl.code     = bus_wdata[CODE_W-1:0];
        end

        if (feed) st_d.pend = 1'b0;

        if (tmo) begin
            if (st_q.ctrl.rst_mode || st_q.pend) begin
                st_d.rst_pulse = 1'b1;
                st_d.pend      = 1'b0;
            end else begin
                st_d.ctrl.flag = 1'b1;
                st_d.pend      = 1'b1;
            end
        end

        if (!st_d.ctrl.en || feed || tmo)   st_d.cnt = '0;
        else if (tick && st_q.ctrl.en)      st_d.cnt = st_q.cnt + CNT_W'(1);

        if (bus_rd && bus_addr == ADDR_CNT_LO) st_d.hi_cap = st_q.cnt[CNT_W-1:HALF_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL:   bus_rdata = st_q.ctrl;
            ADDR_CNT_LO: bus_rdata = st_q.cnt[HALF_W-1:0];
            ADDR_CNT_HI: bus_rdata = st_q.hi_cap;
            default:     bus_rdata = '0;
        endcase
    end

    assign wdt_irq     = st_q.ctrl.flag;
    assign wdt_sys_rst = st_q.rst_pulse;

    // R6: a disabled watchdog keeps its counter at zero
    a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.en |-> st_q.cnt == '0);

    // R2: reserved control bits never hold a one
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.zero13 && st_q.ctrl.zero_mid == '0);

    // R13: a completed feed clears the counter and suppresses a reset
    a_r13_feed_wins: assert property (@(posedge clk) disable iff (!rst_n)
        feed |=> (st_q.cnt == '0) && !wdt_sys_rst);

    // R9: the flag only rises after a timeout in interrupt mode
    a_r9_flag_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_irq) |-> !$past(st_q.ctrl.rst_mode) && st_q.cnt == '0);

endmodule

// File: tb/tb_keyed_watchdog.sv
module tb_keyed_watchdog;

    localparam int unsigned SHORT = 3;
    localparam int unsigned BASE  = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        wdt_irq, wdt_sys_rst;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit cmp_on = 0;

    always #4 clk = ~clk;

    keyed_watchdog #(.SHORT_TICKS(SHORT), .BASE_TICKS(BASE)) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_irq(wdt_irq), .wdt_sys_rst(wdt_sys_rst)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- reference model built from the requirements ----------------
    logic [15:0] m_ctrl;
    logic [31:0] m_cnt;
    logic        m_pend, m_rst;
    logic [15:0] m_hi;
    int          m_seq; // 0 idle, 1 load1, 2 load2, 3 feed1

    function automatic logic [31:0] m_limit(input logic [7:0] code);
        if (code == 0 || (code & (code - 8'd1)) != 0) return 32'h0;
        if (code[0]) return 32'(SHORT);
        for (int i = 1; i < 8; i++) if (code[i]) return 32'(BASE) << (i - 1);
        return 32'h0;
    endfunction

    function automatic int m_first(input logic [15:0] w);
        if (w == 16'h3333) return 1;
        if (w == 16'hAAAA) return 3;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_cnt = 0; m_pend = 0; m_rst = 0; m_hi = 0; m_seq = 0;
        end else begin
            logic ld, fd, to, en_new;
            logic [31:0] lim;
            logic [15:0] nctrl;
            ld = 0; fd = 0;
            if (bus_wr && bus_addr == 2'd0) begin
                case (m_seq)
                    2: begin ld = 1; m_seq = 0; end
                    1: m_seq = (bus_wdata == 16'hCCCC) ? 2 : m_first(bus_wdata);
                    3: if (bus_wdata == 16'h5555) begin fd = 1; m_seq = 0; end
                       else m_seq = m_first(bus_wdata);
                    default: m_seq = m_first(bus_wdata);
                endcase
            end
            lim = m_limit(m_ctrl[7:0]);
            to = m_ctrl[15] && tick && !fd && lim != 0 && (m_cnt + 1 == lim);
            nctrl = m_ctrl;
            if (ld) nctrl = {bus_wdata[15:14], 1'b0, m_ctrl[12] & bus_wdata[12], 4'h0, bus_wdata[7:0]};
            if (bus_rd && bus_addr == 2'd1) m_hi = m_cnt[31:16];
            m_rst = 0;
            if (fd) m_pend = 0;
            if (to) begin
                if (m_ctrl[14] || m_pend) begin m_rst = 1; m_pend = 0; end
                else begin nctrl[12] = 1; m_pend = 1; end
            end
            en_new = nctrl[15];
            if (!en_new || fd || to) m_cnt = 0;
            else if (tick && m_ctrl[15]) m_cnt = m_cnt + 1;
            m_ctrl = nctrl;
        end
    end

    function automatic logic [15:0] m_rdata(input logic [1:0] a);
        case (a)
            2'd0: return m_ctrl;
            2'd1: return m_cnt[15:0];
            2'd2: return m_hi;
            default: return 16'h0;
        endcase
    endfunction

    // Lockstep comparison, 2 ns after each edge (inputs change at negedge)
    always @(posedge clk) begin
        #2;
        if (cmp_on && rst_n) begin
            check("R7 model rst", wdt_sys_rst, m_rst);
            check("R9 model irq", wdt_irq, m_ctrl[12]);
            check("R12 model rdata", bus_rdata, m_rdata(bus_addr));
        end
    end

    // ---------------- bus tasks ----------------
    task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic t = 1'b0);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_wdata = d; tick = t;
        @(negedge clk);
        bus_wr = 0; tick = 0; bus_addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk);
        bus_rd = 1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 0; bus_addr = 2'd0;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1;
        repeat (n) @(negedge clk);
        tick = 0;
    endtask

    task automatic load(input logic [15:0] v);
        wr(0, 16'h3333); wr(0, 16'hCCCC); wr(0, v);
    endtask

    task automatic feed();
        wr(0, 16'hAAAA); wr(0, 16'h5555);
    endtask

    function automatic logic [15:0] pick_word(input int unsigned r);
        case (r % 6)
            0: return 16'h3333;
            1: return 16'hCCCC;
            2: return 16'hAAAA;
            3: return 16'h5555;
            4: return 16'h8000 | 16'(1 << ($urandom % 8)) | ($urandom % 2 ? 16'h4000 : 16'h0);
            default: return 16'($urandom);
        endcase
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        cmp_on = 1;

        // R1 reset state
        rd(0, d); check("R1 ctrl", d, 16'h0);
        rd(1, d); check("R1 cnt", d, 16'h0);
        check("R1 irq", wdt_irq, 0);
        check("R1 rst", wdt_sys_rst, 0);

        // R3 plain write ignored
        wr(0, 16'h1234);
        rd(0, d); check("R3 plain write", d, 16'h0);

        // R2/R11 load with reserved bits and flag written 1
        load(16'hBF02);
        rd(0, d); check("R2 R11 load masks", d, 16'h8002);

        // R6 counting
        ticks(4);
        rd(1, d); check("R6 count", d, 16'd4);

        // R4 feed
        feed();
        rd(1, d); check("R4 feed clears", d, 16'd0);
        rd(0, d); check("R4 ctrl unchanged", d, 16'h8002);

        // R5 broken sequences re-evaluated
        ticks(2);
        wr(0, 16'h3333); feed();
        rd(1, d); check("R5 3333 then feed", d, 16'd0);
        wr(0, 16'hAAAA); wr(3, 16'h1111); load(16'h8004);
        rd(0, d); check("R5 AAAA then load", d, 16'h8004);

        // R9 interrupt timeout (limit 10)
        ticks(10);
        check("R9 irq set", wdt_irq, 1);
        check("R9 no rst", wdt_sys_rst, 0);
        rd(1, d); check("R9 restart", d, 16'd0);
        rd(0, d); check("R9 flag bit", d, 16'h9004);

        // R10 escalation, R7 single cycle pulse
        ticks(10);
        check("R10 escalated rst", wdt_sys_rst, 1);
        @(negedge clk);
        check("R7 single pulse", wdt_sys_rst, 0);

        // R11 flag clear rules
        load(16'h9004);
        check("R11 write one keeps", wdt_irq, 1);
        load(16'h8001);
        check("R11 clear", wdt_irq, 0);

        // R10 feed between timeouts
        feed();
        ticks(3);
        check("R10 first irq", wdt_irq, 1);
        feed();
        ticks(3);
        check("R10 fed no rst", wdt_sys_rst, 0);
        ticks(3);
        check("R10 unfed rst", wdt_sys_rst, 1);

        // R7 reset mode limits
        load(16'hC004); feed();
        ticks(9);
        check("R7 before limit", wdt_sys_rst, 0);
        ticks(1);
        check("R7 at limit code04", wdt_sys_rst, 1);
        load(16'hC080); feed();
        ticks(319);
        check("R7 before limit code80", wdt_sys_rst, 0);
        ticks(1);
        check("R7 at limit code80", wdt_sys_rst, 1);

        // R8 invalid code never times out
        load(16'hC003); feed();
        ticks(400);
        rd(1, d); check("R8 no timeout", d, 16'd400);

        // R13 feed and limit tick on one edge
        load(16'hC001); feed();
        ticks(2);
        wr(0, 16'hAAAA);
        wr(0, 16'h5555, 1'b1);
        check("R13 no rst", wdt_sys_rst, 0);
        rd(1, d); check("R13 counter cleared", d, 16'd0);

        // R12 split read
        load(16'h8000); feed();
        ticks(70000);
        rd(1, d); check("R12 low", d, 16'h1170);
        rd(2, d); check("R12 high", d, 16'h0001);
        ticks(5);
        rd(2, d); check("R12 high held", d, 16'h0001);
        rd(1, d); check("R12 low later", d, 16'h1175);

        // Random phase against the model
        for (int n = 0; n < 3000; n++) begin
            int unsigned r;
            r = $urandom;
            @(negedge clk);
            tick = r[0];
            bus_wr = (r[3:1] < 3);
            bus_rd = r[4];
            bus_addr = (r[7:5] < 6) ? 2'd0 : 2'(r[9:8]);
            bus_wdata = pick_word($urandom);
        end
        @(negedge clk);
        bus_wr = 0; bus_rd = 0; tick = 0;
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule